// File: doc/BRIEF.md
# Dual-Channel Programmable Delay Line

This block holds back two 4-bit fields of an 8-bit word by a chosen number of clock periods. Each field runs through its own chain of seventeen shift registers. A tap multiplexer then picks one chain register and loads it into a final output register. The shortest route is two chain registers plus the output register, so the delay runs from 3 to 18 periods.

A 4-bit length code sets the delay for both fields. A mode bit can instead hold the upper field at the longest delay while the lower field still follows the code. The code and the mode pass through a control register before they steer the multiplexers. A new setting changes only which tap is read, so the data already in the chains is kept, and the output moves to the new tap without any flush. Use it to match pipeline latencies between two paths, or to delay a control nibble by a fixed amount beside a variable one.

Top module: `dly_line_top`

## Requirements
- R1: Bits 3..0 and bits 7..4 of `din` are delayed in separate chains: each output field depends only on the matching input field.
- R2: With length code n (0 to 15), the value of a field sampled at clock edge k appears on `dout` right after edge k+n+2, a delay of n+3 periods.
- R3: Code 0 gives the minimum delay of 3 periods and code 15 gives the maximum delay of 18 periods.
- R4: With `mode` = 0, both fields use the delay set by the code.
- R5: With `mode` = 1, bits 7..4 are delayed by 18 periods whatever the code, and bits 3..0 still follow the code.
- R6: `len_code` and `mode` are captured at a rising edge. The output register loaded at the next edge is the first to use the new values.
- R7: Changing the code or the mode does not disturb data already held in the chains. From the first edge that uses the new tap, the output shows the older sample at that tap, with no flush.
- R8: A synchronous active-high `rst` clears the chains, the output register and the captured controls (code 0, mode 0), so `dout` reads 0 while reset is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all registers update on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 8 | Data word; bits 3..0 are the lower field, bits 7..4 the upper field |
| len_code | input | 4 | Length code; delay is code + 3 periods |
| mode | input | 1 | 0: both fields follow the code; 1: upper field fixed at 18 periods |
| dout | output | 8 | Delayed data word from the output registers |

## Verification
Some rules are checked by assertions on every cycle. A tap select must always lie in the legal range of chain registers 2 to 17. Under mode 0 both fields must share one select, and under mode 1 the upper select must stay on the last register. At the minimum and maximum taps the output register must load the chain value from the right earlier edge. Other behaviours need the bench's scenarios, which compare every output against a history of past inputs. These are the exact n+3 delay for each of the sixteen codes, the one-edge lag of the control register, the contents kept across a long-to-short-to-long change of code, and the cleared state under reset.

// File: rtl/dly_pkg.sv
`timescale 1ns/1ps
package dly_pkg;

    localparam int FIELD_W    = 4;
    localparam int NUM_FIELDS = 2;
    localparam int CODE_W     = 4;
    localparam int MIN_TAP    = 2;

    typedef enum logic {
        LEN_SHARED   = 1'b0,
        UPPER_PINNED = 1'b1
    } dly_mode_e;

endpackage

// File: rtl/dly_ctrl_reg.sv
`timescale 1ns/1ps
module dly_ctrl_reg
    import dly_pkg::*;
#(
    parameter int CODE_W = dly_pkg::CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code_in,
    input  dly_mode_e         mode_in,
    output logic [CODE_W-1:0] code_q,
    output dly_mode_e         mode_q
);

    typedef struct packed {
        logic [CODE_W-1:0] code;
        dly_mode_e         mode;
    } ctrl_t;

    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.code <= '0;
            ctrl_q.mode <= LEN_SHARED;
        end else begin
            ctrl_q.code <= code_in;
            ctrl_q.mode <= mode_in;
        end
    end

    assign code_q = ctrl_q.code;
    assign mode_q = ctrl_q.mode;

endmodule

// File: rtl/dly_tap_sel.sv
`timescale 1ns/1ps
module dly_tap_sel
    import dly_pkg::*;
#(
    parameter int CODE_W     = dly_pkg::CODE_W,
    parameter int NUM_FIELDS = dly_pkg::NUM_FIELDS,
    parameter int MIN_TAP    = dly_pkg::MIN_TAP,
    parameter int LAST_TAP   = MIN_TAP + (1 << CODE_W) - 1,
    parameter int SEL_W      = $clog2(LAST_TAP + 1)
) (
    input  logic [CODE_W-1:0]                  code_q,
    input  dly_mode_e                          mode_q,
    output logic [NUM_FIELDS-1:0][SEL_W-1:0]   sel
);

    logic [SEL_W-1:0] base_tap;

    // code n reads chain register n+2
    assign base_tap = SEL_W'(code_q) + SEL_W'(MIN_TAP);

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : gen_sel
        if (f == NUM_FIELDS - 1) begin : gen_upper
            assign sel[f] = (mode_q == UPPER_PINNED) ? SEL_W'(LAST_TAP) : base_tap;
        end else begin : gen_lower
            assign sel[f] = base_tap;
        end
    end

endmodule

// File: rtl/dly_chain.sv
`timescale 1ns/1ps
module dly_chain #(
    parameter int W       = 4,
    parameter int LEN     = 17,
    parameter int MIN_TAP = 2,
    parameter int SEL_W   = $clog2(LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [W-1:0]     din,
    input  logic [SEL_W-1:0] sel,
    output logic [W-1:0]     tail,
    output logic [W-1:0]     dout
);

    // stg[i] is chain register i+1
    logic [W-1:0] stg [LEN];
    logic [W-1:0] tap;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LEN; i++) begin
                stg[i] <= '0;
            end
        end else begin
            stg[0] <= din;
            for (int i = 1; i < LEN; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    always_comb begin
        tap = stg[MIN_TAP-1];
        for (int i = MIN_TAP; i <= LEN; i++) begin
            if (sel == SEL_W'(i)) begin
                tap = stg[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else begin
            dout <= tap;
        end
    end

    assign tail = stg[LEN-1];

    // R2: the select from the control path always names a legal register
    a_r2_sel_legal: assert property (@(posedge clk) disable iff (rst)
        (sel >= SEL_W'(MIN_TAP)) && (sel <= SEL_W'(LEN)));

    // R3: shortest path is register 1, register 2, output register
    a_r3_min_path: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_W'(MIN_TAP)) && !$past(rst) |=> dout == $past(stg[0], 2));

endmodule

// File: rtl/dly_line_top.sv
`timescale 1ns/1ps
module dly_line_top
    import dly_pkg::*;
#(
    parameter int FIELD_W    = dly_pkg::FIELD_W,
    parameter int NUM_FIELDS = dly_pkg::NUM_FIELDS,
    parameter int CODE_W     = dly_pkg::CODE_W,
    parameter int MIN_TAP    = dly_pkg::MIN_TAP,
    localparam int DATA_W    = FIELD_W * NUM_FIELDS,
    localparam int CHAIN_LEN = MIN_TAP + (1 << CODE_W) - 1,
    localparam int SEL_W     = $clog2(CHAIN_LEN + 1),
    localparam int HI        = NUM_FIELDS - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] din,
    input  logic [CODE_W-1:0] len_code,
    input  logic              mode,
    output logic [DATA_W-1:0] dout
);

    logic [CODE_W-1:0]                code_q;
    dly_mode_e                        mode_q;
    logic [NUM_FIELDS-1:0][SEL_W-1:0] sel;
    logic [NUM_FIELDS-1:0][FIELD_W-1:0] tail;

    dly_ctrl_reg #(.CODE_W(CODE_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .code_in (len_code),
        .mode_in (dly_mode_e'(mode)),
        .code_q  (code_q),
        .mode_q  (mode_q)
    );

    dly_tap_sel #(
        .CODE_W     (CODE_W),
        .NUM_FIELDS (NUM_FIELDS),
        .MIN_TAP    (MIN_TAP),
        .LAST_TAP   (CHAIN_LEN),
        .SEL_W      (SEL_W)
    ) u_sel (
        .code_q (code_q),
        .mode_q (mode_q),
        .sel    (sel)
    );

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : gen_field
        dly_chain #(
            .W       (FIELD_W),
            .LEN     (CHAIN_LEN),
            .MIN_TAP (MIN_TAP),
            .SEL_W   (SEL_W)
        ) u_chain (
            .clk  (clk),
            .rst  (rst),
            .din  (din[f*FIELD_W +: FIELD_W]),
            .sel  (sel[f]),
            .tail (tail[f]),
            .dout (dout[f*FIELD_W +: FIELD_W])
        );

        // R3: longest tap loads the last chain register into the output
        a_r3_max_path: assert property (@(posedge clk) disable iff (rst)
            (sel[f] == SEL_W'(CHAIN_LEN)) |=> dout[f*FIELD_W +: FIELD_W] == $past(tail[f]));
    end

    // R4: shared mode steers every field from one select
    a_r4_shared_sel: assert property (@(posedge clk) disable iff (rst)
        (mode_q == LEN_SHARED) |-> sel[HI] == sel[0]);

    // R5: pinned mode holds the upper field on the last register
    a_r5_upper_pinned: assert property (@(posedge clk) disable iff (rst)
        (mode_q == UPPER_PINNED) |-> sel[HI] == SEL_W'(CHAIN_LEN));

endmodule

// File: tb/sim_dly_line_top.sv
`timescale 1ns/1ps
module sim_dly_line_top;

    localparam int HMAX = 4096;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] din = '0;
    logic [3:0] len_code = '0;
    logic       mode = 1'b0;
    logic [7:0] dout;

    logic [7:0] d_hist [HMAX];
    logic [3:0] c_hist [HMAX];
    logic       m_hist [HMAX];
    int cyc = 0;
    int n_checks = 0;
    int n_fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dly_line_top u0 (
        .clk      (clk),
        .rst      (rst),
        .din      (din),
        .len_code (len_code),
        .mode     (mode),
        .dout     (dout)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s cycle %0d: dout=%h expected %h", tag, cyc, act, exp);
        end
    endtask

    // one clock: drive at the falling edge, record, sample 2 ns after the rising edge
    task automatic step(input logic [7:0] d, input logic [3:0] c, input logic m,
                        input bit r, input bit chk, input string tag);
        int e;
        int lo_t;
        int hi_t;
        logic [7:0] exp;
        @(negedge clk);
        rst = r; din = d; len_code = c; mode = m;
        @(posedge clk);
        e = cyc;
        d_hist[e] = r ? 8'h00 : d;
        c_hist[e] = r ? 4'h0 : c;
        m_hist[e] = r ? 1'b0 : m;
        cyc++;
        #2;
        if (chk) begin
            if (r) begin
                exp = 8'h00;
            end else begin
                lo_t = int'(c_hist[e-1]) + 2;
                hi_t = m_hist[e-1] ? 17 : lo_t;
                exp = {d_hist[e-hi_t][7:4], d_hist[e-lo_t][3:0]};
            end
            check(tag, dout, exp);
        end
    endtask

    // R8: reset clears chains, output and controls even with busy inputs
    task automatic t_reset();
        step(8'hFF, 4'hF, 1'b1, 1'b1, 1'b0, "R8");
        for (int i = 0; i < 19; i++) step(8'hA5, 4'hF, 1'b1, 1'b1, 1'b1, "R8");
    endtask

    // R1 R2 R4: every code in shared mode with independent random fields
    task automatic t_code_sweep();
        for (int c = 0; c < 16; c++) begin
            for (int i = 0; i < 40; i++) begin
                step(8'($urandom), 4'(c), 1'b0, 1'b0, 1'b1,
                     (c == 0 || c == 15) ? "R3 R2 R4" : "R1 R2 R4");
            end
        end
    endtask

    // R5: upper field fixed at 18 while the lower field follows the code
    task automatic t_pinned();
        for (int c = 15; c >= 0; c--) begin
            for (int i = 0; i < 30; i++) begin
                step(8'($urandom), 4'(c), 1'b1, 1'b0, 1'b1, "R5");
            end
        end
    endtask

    // R6: controls change every edge; each output uses the values captured one edge earlier
    task automatic t_ctrl_latency();
        for (int i = 0; i < 200; i++) begin
            step(8'($urandom), 4'($urandom), 1'($urandom), 1'b0, 1'b1, "R6");
        end
    endtask

    // R7: long, short, long again; chain data kept, output follows the new tap at once
    task automatic t_midstream();
        for (int k = 0; k < 4; k++) begin
            for (int i = 0; i < 25; i++) step(8'($urandom), 4'hF, 1'b0, 1'b0, 1'b1, "R7");
            for (int i = 0; i < 5; i++)  step(8'($urandom), 4'h0, 1'b0, 1'b0, 1'b1, "R7");
            for (int i = 0; i < 5; i++)  step(8'($urandom), 4'hF, 1'b0, 1'b0, 1'b1, "R7");
            for (int i = 0; i < 6; i++)  step(8'($urandom), 4'(k * 3 + 1), 1'b1, 1'b0, 1'b1, "R7");
            for (int i = 0; i < 6; i++)  step(8'($urandom), 4'(k * 3 + 1), 1'b0, 1'b0, 1'b1, "R7");
        end
    endtask

    // R1: lower field moves while upper field is constant, then the reverse
    task automatic t_field_isolation();
        for (int i = 0; i < 30; i++) step({4'h6, 4'(i)}, 4'h5, 1'b0, 1'b0, 1'b1, "R1");
        for (int i = 0; i < 30; i++) step({4'(i), 4'h9}, 4'h5, 1'b0, 1'b0, 1'b1, "R1");
    endtask

    initial begin
        t_reset();
        t_code_sweep();
        t_pinned();
        t_ctrl_latency();
        t_midstream();
        t_field_isolation();
        t_reset();
        for (int i = 0; i < 30; i++) step(8'($urandom), 4'h7, 1'b0, 1'b0, 1'b1, "R8 R2");
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #500us;
        if (!done) begin
            done = 1'b1;
            n_fails++;
            $display("FAIL watchdog expired at cycle %0d: dout=%h expected completion", cyc, dout);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule